// File: doc/BRIEF.md
# Descriptor Chain Queue Engine

This block looks after a single queue of DMA descriptors. The descriptors sit as a linked list in a word-addressed descriptor RAM. The queue is held as a head pointer plus a fixed terminator descriptor at address `TERM_ADDR`. The queue holds no entries when the head points at the terminator.

Each descriptor takes five 32-bit words:

| Word | Bits [31:16] | Bits [15:0] |
|------|--------------|-------------|
| 0 | control | status |
| 1 | total length | data size |
| 2 | last-descriptor pointer (low `ADDR_W` bits) | |
| 3 | data buffer pointer | |
| 4 | next-descriptor pointer (low `ADDR_W` bits) | |

Status bits [1:0] carry ownership:

| Code | Owner |
|------|-------|
| 0 | software |
| 1 | hardware |
| 2 | engine |

A multi-segment packet starts at the head. The head's last-descriptor pointer names the final segment of that packet, and the final segment's next pointer names the next packet.

Commands use a valid/busy/done handshake. The opcodes are:

| Code | Command |
|------|---------|
| 0 | empty test |
| 1 | dequeue-if-owner-equal |
| 2 | dequeue-if-owner-differs |
| 3 | rearm |
| 4 | reinitialise as receive buffer |
| 5 | length count |
| 6 | load head |
| 7 | no operation |

RAM reads return data one cycle after `mem_en`.

Top module: `dq_chain_mgr`

## Requirements
- R1: After reset `q_head` equals `TERM_ADDR`, and `busy` and `done` are 0.
- R2: Opcode 0 finishes with `rsp_empty` = 1 exactly when `q_head` equals `TERM_ADDR`.
- R3: Opcode 1 removes the head packet when head status bits [1:0] equal `cmd_own`. It finishes with `rsp_hit` = 1 and `rsp_desc` = the old head.
- R4: Opcode 2 removes the head packet when head status bits [1:0] differ from `cmd_own`. It finishes with `rsp_hit` = 1 and `rsp_desc` = the old head.
- R5: A removal sets `q_head` to word 4 of the descriptor named by word 2 of the old head. This skips every segment of the packet.
- R6: A dequeue on an empty queue, or one whose ownership test fails, ends with `rsp_hit` = 0, `rsp_desc` = `TERM_ADDR` and `q_head` unchanged.
- R7: Opcode 3 rewrites word 0 of descriptor `cmd_arg` with bits [1:0] = 1 and bits [31:2] kept.
- R8: Opcode 4 sets up descriptor `cmd_arg` as an empty receive buffer:
  - word 0 = 0x00000001;
  - word 1 = 320 in bits [31:16] and 0 in bits [15:0];
  - word 2 = `cmd_arg`.
  No other word is written.
- R9: Opcode 5 follows word 4 from the head until it reaches the terminator. It reports the number of descriptors in `rsp_count`, which is 0 on an empty queue.
- R10: `rsp_count` saturates at 2^`CNT_W`-1.
- R11: A count that has visited `STEP_LIMIT` descriptors without reaching the terminator stops and finishes with `rsp_err` = 1.
- R12: Every command raises `done` for exactly one cycle. A command presented while `busy` is 1 is ignored.
- R13: Opcode 6 loads `q_head` with `cmd_arg`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 3 | Opcode |
| cmd_arg | input | ADDR_W | Descriptor address or new head |
| cmd_own | input | 2 | Ownership code for dequeue tests |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| rsp_hit | output | 1 | Dequeue took a packet |
| rsp_err | output | 1 | Count hit the step limit |
| rsp_empty | output | 1 | Result of empty test |
| rsp_desc | output | ADDR_W | Removed packet head, or terminator on a miss |
| rsp_count | output | CNT_W | Descriptor count |
| q_head | output | ADDR_W | Current head pointer |
| mem_en | output | 1 | RAM access enable |
| mem_we | output | 1 | RAM write enable |
| mem_addr | output | ADDR_W | RAM word address |
| mem_wdata | output | 32 | RAM write data |
| mem_rdata | input | 32 | RAM read data, one cycle after `mem_en` |

## Verification
The checker watches several properties on every cycle:
- `done` never coincides with `busy`;
- work only starts on a request;
- a hit always reports the head that was current before the removal;
- the head moves only on a completion;
- writes to RAM only happen inside a command;
- an error never comes with a hit.

Some behaviour only the directed scenarios can show, because it needs the linked list laid out in RAM:
- the skip through the last-descriptor link;
- the exact word images left by rearm and reinitialise;
- the descriptor count;
- its saturation;
- the abort on a looping chain.

// File: rtl/dq_chain_mgr.sv
module dq_chain_mgr #(
  parameter int ADDR_W = 12,
  parameter int CNT_W = 8,
  parameter int STEP_LIMIT = 1024,
  parameter int BLOCK_LEN = 320,
  parameter logic [ADDR_W-1:0] TERM_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_arg,
  input  logic [1:0]        cmd_own,
  output logic              busy,
  output logic              done,
  output logic              rsp_hit,
  output logic              rsp_err,
  output logic              rsp_empty,
  output logic [ADDR_W-1:0] rsp_desc,
  output logic [CNT_W-1:0]  rsp_count,
  output logic [ADDR_W-1:0] q_head,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata
);

  localparam int SW = $clog2(STEP_LIMIT + 1);
  localparam logic [SW-1:0] LIM = SW'(STEP_LIMIT);
  localparam logic [ADDR_W-1:0] W_LEN  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] W_LAST = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] W_NEXT = ADDR_W'(4);
  localparam logic [1:0] OWN_HW = 2'd1;

  localparam logic [2:0] OP_EMPTY = 3'd0, OP_DQ_EQ = 3'd1, OP_DQ_NE = 3'd2,
                         OP_REARM = 3'd3, OP_REINIT = 3'd4, OP_COUNT = 3'd5,
                         OP_LOAD = 3'd6;

  typedef enum logic [2:0] {
    S_IDLE, S_DQ_ST, S_DQ_LAST, S_DQ_NEXT, S_RA, S_RI1, S_RI2, S_CNT
  } st_t;

  st_t               state;
  logic [ADDR_W-1:0] ptr;
  logic [1:0]        own_r;
  logic              ne_r;
  logic [CNT_W-1:0]  cnt;
  logic [SW-1:0]     steps;

  wire              accept    = cmd_valid && (state == S_IDLE);
  wire              head_term = (q_head == TERM_ADDR);
  wire [ADDR_W-1:0] rd_ptr    = mem_rdata[ADDR_W-1:0];
  wire              own_ok    = (mem_rdata[1:0] == own_r) ^ ne_r;
  wire [CNT_W-1:0]  cnt_n     = (cnt == '1) ? cnt : cnt + 1'b1;
  wire [SW-1:0]     steps_n   = steps + 1'b1;
  wire              rd_term   = (rd_ptr == TERM_ADDR);
  wire              at_limit  = (steps_n >= LIM);

  assign busy = (state != S_IDLE);

  always_comb begin
    mem_en    = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = ptr;
    mem_wdata = '0;
    case (state)
      S_IDLE: if (cmd_valid) begin
        case (cmd_op)
          OP_DQ_EQ, OP_DQ_NE: if (!head_term) begin
            mem_en   = 1'b1;
            mem_addr = q_head;
          end
          OP_REARM: begin
            mem_en   = 1'b1;
            mem_addr = cmd_arg;
          end
          OP_REINIT: begin
            mem_en    = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = cmd_arg;
            mem_wdata = {16'h0000, 14'h0, OWN_HW};
          end
          OP_COUNT: if (!head_term) begin
            mem_en   = 1'b1;
            mem_addr = q_head + W_NEXT;
          end
          default: ;
        endcase
      end
      S_DQ_ST: if (own_ok) begin
        mem_en   = 1'b1;
        mem_addr = ptr + W_LAST;
      end
      S_DQ_LAST: begin
        mem_en   = 1'b1;
        mem_addr = rd_ptr + W_NEXT;
      end
      S_RA: begin
        mem_en    = 1'b1;
        mem_we    = 1'b1;
        mem_wdata = {mem_rdata[31:2], OWN_HW};
      end
      S_RI1: begin
        mem_en    = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = ptr + W_LEN;
        mem_wdata = {16'(BLOCK_LEN), 16'h0000};
      end
      S_RI2: begin
        mem_en    = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = ptr + W_LAST;
        mem_wdata = 32'(ptr);
      end
      S_CNT: if (!rd_term && !at_limit) begin
        mem_en   = 1'b1;
        mem_addr = rd_ptr + W_NEXT;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      q_head    <= TERM_ADDR;
      ptr       <= TERM_ADDR;
      own_r     <= '0;
      ne_r      <= 1'b0;
      cnt       <= '0;
      steps     <= '0;
      done      <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_empty <= 1'b0;
      rsp_desc  <= TERM_ADDR;
      rsp_count <= '0;
    end else begin
      done    <= 1'b0;
      rsp_hit <= 1'b0;
      rsp_err <= 1'b0;
      case (state)
        S_IDLE: if (accept) begin
          ptr   <= cmd_arg;
          own_r <= cmd_own;
          ne_r  <= (cmd_op == OP_DQ_NE);
          case (cmd_op)
            OP_EMPTY: begin
              rsp_empty <= head_term;
              done      <= 1'b1;
            end
            OP_DQ_EQ, OP_DQ_NE: begin
              ptr <= q_head;
              if (head_term) begin
                rsp_desc <= TERM_ADDR;
                done     <= 1'b1;
              end else begin
                state <= S_DQ_ST;
              end
            end
            OP_REARM:  state <= S_RA;
            OP_REINIT: state <= S_RI1;
            OP_COUNT: begin
              cnt   <= '0;
              steps <= '0;
              if (head_term) begin
                rsp_count <= '0;
                done      <= 1'b1;
              end else begin
                state <= S_CNT;
              end
            end
            OP_LOAD: begin
              q_head <= cmd_arg;
              done   <= 1'b1;
            end
            default: done <= 1'b1;
          endcase
        end
        S_DQ_ST: begin
          if (own_ok) begin
            state <= S_DQ_LAST;
          end else begin
            rsp_desc <= TERM_ADDR;
            done     <= 1'b1;
            state    <= S_IDLE;
          end
        end
        S_DQ_LAST: state <= S_DQ_NEXT;
        S_DQ_NEXT: begin
          q_head   <= rd_ptr;
          rsp_desc <= ptr;
          rsp_hit  <= 1'b1;
          done     <= 1'b1;
          state    <= S_IDLE;
        end
        S_RA: begin
          done  <= 1'b1;
          state <= S_IDLE;
        end
        S_RI1: state <= S_RI2;
        S_RI2: begin
          done  <= 1'b1;
          state <= S_IDLE;
        end
        S_CNT: begin
          if (rd_term || at_limit) begin
            rsp_count <= cnt_n;
            rsp_err   <= !rd_term;
            done      <= 1'b1;
            state     <= S_IDLE;
          end else begin
            cnt   <= cnt_n;
            steps <= steps_n;
            ptr   <= rd_ptr;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dq_chain_mgr_chk.sv
module dq_chain_mgr_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              busy,
  input logic              done,
  input logic              rsp_hit,
  input logic              rsp_err,
  input logic [ADDR_W-1:0] rsp_desc,
  input logic [ADDR_W-1:0] q_head,
  input logic              mem_we
);

  // R12
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R12
  start_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_valid));

  // R3
  hit_old_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> (done && rsp_desc == $past(q_head)));

  // R6
  head_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q_head != $past(q_head)) |-> done);

  // R8
  write_in_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (busy || cmd_valid));

  // R11
  err_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (done && !rsp_hit));

endmodule

bind dq_chain_mgr dq_chain_mgr_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_dq_chain_mgr.sv
module sim_dq_chain_mgr;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_op = '0;
  logic [7:0] cmd_arg = '0;
  logic [1:0] cmd_own = '0;
  logic busy, done, rsp_hit, rsp_err, rsp_empty;
  logic [7:0] rsp_desc, q_head, mem_addr;
  logic [2:0] rsp_count;
  logic mem_en, mem_we;
  logic [31:0] mem_wdata, mem_rdata;
  logic [31:0] mem [0:255];
  int nvec = 0;
  int nbad = 0;

  always #2 clk = ~clk;

  dq_chain_mgr #(.ADDR_W(8), .CNT_W(3), .STEP_LIMIT(12), .BLOCK_LEN(320),
                 .TERM_ADDR(8'd0)) u0 (.*);

  always_ff @(posedge clk) if (mem_en) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic mkdesc(input int a, input logic [31:0] w0, input int last, input int nxt);
    mem[a] = w0; mem[a+1] = 32'h0; mem[a+2] = 32'(last);
    mem[a+3] = 32'h0; mem[a+4] = 32'(nxt);
  endtask

  task automatic run(input logic [2:0] op, input logic [7:0] arg, input logic [1:0] own);
    int n = 0;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_arg = arg; cmd_own = own;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (!done && n < 60) begin @(negedge clk); n++; end
    chk("R12 done seen", 32'(done), 32'd1);
  endtask

  task automatic t_reset;
    chk("R1 head", 32'(q_head), 32'd0);
    chk("R1 busy", 32'(busy), 32'd0);
    chk("R1 done", 32'(done), 32'd0);
    run(3'd0, 8'd0, 2'd0);
    chk("R2 empty after reset", 32'(rsp_empty), 32'd1);
  endtask

  task automatic t_dequeue;
    mkdesc(5, 32'h0200_0000, 10, 10);
    mkdesc(10, 32'h0100_0000, 10, 15);
    mkdesc(15, 32'h0300_0001, 15, 0);
    run(3'd6, 8'd5, 2'd0);
    chk("R13 head loaded", 32'(q_head), 32'd5);
    run(3'd0, 8'd0, 2'd0);
    chk("R2 not empty", 32'(rsp_empty), 32'd0);
    run(3'd1, 8'd0, 2'd1);
    chk("R6 eq miss hit", 32'(rsp_hit), 32'd0);
    chk("R6 eq miss desc", 32'(rsp_desc), 32'd0);
    chk("R6 eq miss head", 32'(q_head), 32'd5);
    run(3'd1, 8'd0, 2'd0);
    chk("R3 eq hit", 32'(rsp_hit), 32'd1);
    chk("R3 eq desc", 32'(rsp_desc), 32'd5);
    chk("R5 skip segments", 32'(q_head), 32'd15);
    run(3'd2, 8'd0, 2'd1);
    chk("R6 ne miss hit", 32'(rsp_hit), 32'd0);
    chk("R6 ne miss head", 32'(q_head), 32'd15);
    run(3'd2, 8'd0, 2'd2);
    chk("R4 ne hit", 32'(rsp_hit), 32'd1);
    chk("R4 ne desc", 32'(rsp_desc), 32'd15);
    chk("R5 to terminator", 32'(q_head), 32'd0);
    run(3'd1, 8'd0, 2'd0);
    chk("R6 empty miss", 32'(rsp_hit), 32'd0);
    chk("R6 empty head", 32'(q_head), 32'd0);
  endtask

  task automatic t_count;
    run(3'd5, 8'd0, 2'd0);
    chk("R9 empty count", 32'(rsp_count), 32'd0);
    run(3'd6, 8'd5, 2'd0);
    run(3'd5, 8'd0, 2'd0);
    chk("R9 count", 32'(rsp_count), 32'd3);
    chk("R9 no err", 32'(rsp_err), 32'd0);
  endtask

  task automatic t_saturate;
    for (int k = 0; k < 9; k++) mkdesc(20 + 5*k, 32'h1, 20 + 5*k, (k == 8) ? 0 : 25 + 5*k);
    run(3'd6, 8'd20, 2'd0);
    run(3'd5, 8'd0, 2'd0);
    chk("R10 saturated", 32'(rsp_count), 32'd7);
    chk("R10 no err", 32'(rsp_err), 32'd0);
  endtask

  task automatic t_loop;
    mkdesc(70, 32'h1, 70, 75);
    mkdesc(75, 32'h1, 75, 70);
    run(3'd6, 8'd70, 2'd0);
    run(3'd5, 8'd0, 2'd0);
    chk("R11 err", 32'(rsp_err), 32'd1);
  endtask

  task automatic t_rearm;
    mem[80] = 32'hABCD_1236;
    run(3'd3, 8'd80, 2'd0);
    @(negedge clk);
    chk("R7 rearm 2->1", mem[80], 32'hABCD_1235);
    mem[80] = 32'h8000_0004;
    run(3'd3, 8'd80, 2'd0);
    @(negedge clk);
    chk("R7 rearm 0->1", mem[80], 32'h8000_0005);
  endtask

  task automatic t_reinit;
    for (int k = 85; k < 91; k++) mem[k] = 32'hDEAD_BEEF;
    run(3'd4, 8'd85, 2'd0);
    @(negedge clk);
    chk("R8 word0", mem[85], 32'h0000_0001);
    chk("R8 word1", mem[86], 32'h0140_0000);
    chk("R8 word2", mem[87], 32'd85);
    chk("R8 word3 kept", mem[88], 32'hDEAD_BEEF);
  endtask

  task automatic t_busy;
    mkdesc(100, 32'h0, 100, 0);
    run(3'd6, 8'd100, 2'd0);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'd1; cmd_arg = 8'd0; cmd_own = 2'd0;
    @(negedge clk);
    cmd_op = 3'd6; cmd_arg = 8'd99;
    chk("R12 busy", 32'(busy), 32'd1);
    @(negedge clk);
    cmd_valid = 1'b0;
    while (!done) @(negedge clk);
    chk("R12 dequeue hit", 32'(rsp_hit), 32'd1);
    @(negedge clk);
    chk("R12 done one cycle", 32'(done), 32'd0);
    chk("R12 busy load ignored", 32'(q_head), 32'd0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    for (int k = 0; k < 256; k++) mem[k] = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_dequeue;
    t_count;
    t_saturate;
    t_loop;
    t_rearm;
    t_reinit;
    t_busy;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule